// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial characters on one input line. A one-cycle oversampling strobe, sixteen per bit time, paces a frame engine. The engine finds a start bit, samples each data bit at its centre, takes an optional parity bit, and then checks the first stop bit. The character width can be seven or eight bits. Parity can be off, even or odd. One or two stop bits can follow the character. Every completed character is written to a data register. The block keeps three status flags: data-full, framing error and parity error. Software uses a small register bus to read data and status, to clear the error flags and to select the mode.

The frame engine is a state machine with six states:
- `RX_IDLE` moves to `RX_START` on a falling line edge. It does this only while the receiver is enabled and no error flag is set.
- `RX_START` counts eight strobes. It moves to `RX_DATA` if the line is low at that point. If the line is high, it returns to `RX_IDLE` as a rejected glitch.
- `RX_DATA` samples one bit per sixteen strobes. After the last data bit it moves to `RX_PARITY` when parity is on, or to `RX_STOP1` when it is off.
- `RX_PARITY` samples the parity bit and moves to `RX_STOP1`.
- `RX_STOP1` samples the first stop bit and loads the result into the registers. It then moves to `RX_STOP2` in two-stop mode, and to `RX_IDLE` otherwise.
- `RX_STOP2` waits out the second stop bit without checking it, then returns to `RX_IDLE`.

Clearing the enable bit forces `RX_IDLE` from any state.

Top module: `serial_rx_unit`

## Requirements
- R1: After reset, the data register reads 0x00, the status register reads 0x00 and the control register reads 0x00.
- R2: A start bit is accepted only when the line is still low at the 8th strobe after the falling edge. A shorter low pulse is dropped: nothing is loaded and no flag changes.
- R3: Data bits arrive LSB first. A clean character is loaded into the data register (bus address 0) and sets the full flag (status bit 0). Reading address 0 clears the full flag.
- R4: With control bit 1 (seven-bit mode) set, seven data bits are taken and data register bit 7 reads 0.
- R5: With control bit 2 (parity on) set, a parity bit follows the data. Control bit 3 selects odd parity (1) or even parity (0). The parity error flag (status bit 2) sets when the count of ones in the data and parity bit does not match the selected parity.
- R6: A character with a framing or parity error is still written to the data register, but the full flag is not set by it.
- R7: The framing error flag (status bit 1) sets when the first stop bit is sampled as 0.
- R8: With control bit 4 (two stop bits) set, only the first stop bit is checked; a 0 in the second stop bit causes no error.
- R9: While either error flag is 1, no new character is received. The data register and the flags do not change.
- R10: An error flag clears when status (address 1) is written with that bit 0, after a status read that saw the flag at 1. Any status write ends this armed condition.
- R11: A status write of 0 with no preceding read that saw the flag set has no effect. Writing 1 never sets or clears a flag.
- R12: With control bit 0 (enable) at 0, no reception takes place and both error flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| rxd | input | 1 | Serial input line, idle high |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |

## Verification
- **Register reads:** read data is combinational and due in the same cycle as the address. The bench samples it one nanosecond after the driving negative edge. Read side effects (clearing full, arming a flag for clearing) act at the next rising edge.
- **Character results:** a character's result lands two synchroniser cycles plus one register stage after the centre of its first stop bit. That point is at least half a bit time, 32 clocks, before the frame ends.
- **Check timing:** the bench waits out the whole frame and a further idle bit before it reads the status register. Each check therefore falls after the update is due and before the next stimulus.
- **Expected values:** the bench computes each expected value from the frame it built.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP1, RX_STOP2
    } rx_state_e;

    typedef struct packed {
        logic two_stop;
        logic odd_par;
        logic par_on;
        logic seven;
        logic enable;
    } rx_cfg_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic line,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], rxd};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign line = chain_q[STAGES-1];
    assign fall = prev_q & ~line;
endmodule

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              fall,
    input  rx_cfg_t           cfg,
    input  logic              hold,
    output logic              done,
    output logic [DATA_W-1:0] char_o,
    output logic              ferr_o,
    output logic              perr_o
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0] LAST8    = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0] LAST7    = BIT_W'(DATA_W - 2);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              parbit_q;
    logic              centre;
    logic [BIT_W-1:0]  last_idx;
    logic [DATA_W-1:0] word;

    assign centre   = tick && (cnt_q == LAST_CNT);
    assign last_idx = cfg.seven ? LAST7 : LAST8;
    assign word     = cfg.seven ? {1'b0, shift_q[DATA_W-1:1]} : shift_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!cfg.enable) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:   if (fall && !hold) state_d = RX_START;
                RX_START:  if (tick && cnt_q == MID_CNT) state_d = line ? RX_IDLE : RX_DATA;
                RX_DATA:   if (centre && bit_q == last_idx) state_d = cfg.par_on ? RX_PARITY : RX_STOP1;
                RX_PARITY: if (centre) state_d = RX_STOP1;
                RX_STOP1:  if (centre) state_d = cfg.two_stop ? RX_STOP2 : RX_IDLE;
                RX_STOP2:  if (centre) state_d = RX_IDLE;
                default:   state_d = RX_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            bit_q    <= '0;
            shift_q  <= '0;
            parbit_q <= 1'b0;
            done     <= 1'b0;
            char_o   <= '0;
            ferr_o   <= 1'b0;
            perr_o   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state_d != state_q || state_q == RX_IDLE)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;

            if (state_q == RX_START)
                bit_q <= '0;

            if (cfg.enable) begin
                unique case (state_q)
                    RX_DATA: if (centre) begin
                        shift_q <= {line, shift_q[DATA_W-1:1]};
                        bit_q   <= bit_q + 1'b1;
                    end
                    RX_PARITY: if (centre) parbit_q <= line;
                    RX_STOP1: if (centre) begin
                        done   <= 1'b1;
                        char_o <= word;
                        ferr_o <= ~line;
                        perr_o <= cfg.par_on && (((^word) ^ parbit_q) != cfg.odd_par);
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_hold_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_IDLE && hold) |=> (state_q == RX_IDLE));
    assert_disabled_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.enable |=> (state_q == RX_IDLE));
    assert_load_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state_q) == RX_STOP1));
endmodule

// File: rtl/serial_rx_regs.sv
module serial_rx_regs
    import serial_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] char_i,
    input  logic              ferr_i,
    input  logic              perr_i,
    output rx_cfg_t           cfg,
    output logic              hold
);
    localparam int CFG_W = $bits(rx_cfg_t);

    logic [DATA_W-1:0] data_q;
    logic full_q, fe_q, pe_q, arm_fe_q, arm_pe_q;
    logic rd_data, rd_stat, wr_stat, wr_ctrl;
    logic bus_unused;

    assign rd_data = rd && addr == ADDR_DATA;
    assign rd_stat = rd && addr == ADDR_STAT;
    assign wr_stat = wr && addr == ADDR_STAT;
    assign wr_ctrl = wr && addr == ADDR_CTRL;
    assign hold    = fe_q | pe_q;
    assign bus_unused = &{1'b0, wdata[DATA_W-1:CFG_W], wdata[0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            full_q   <= 1'b0;
            fe_q     <= 1'b0;
            pe_q     <= 1'b0;
            arm_fe_q <= 1'b0;
            arm_pe_q <= 1'b0;
            cfg      <= '0;
        end else begin
            if (wr_ctrl) cfg <= rx_cfg_t'(wdata[CFG_W-1:0]);
            if (rd_data) full_q <= 1'b0;
            if (rd_stat) begin
                arm_fe_q <= fe_q;
                arm_pe_q <= pe_q;
            end
            if (wr_stat) begin
                if (arm_fe_q && !wdata[1]) fe_q <= 1'b0;
                if (arm_pe_q && !wdata[2]) pe_q <= 1'b0;
                arm_fe_q <= 1'b0;
                arm_pe_q <= 1'b0;
            end
            if (done) begin
                data_q <= char_i;
                if (!ferr_i && !perr_i) full_q <= 1'b1;
                if (ferr_i) fe_q <= 1'b1;
                if (perr_i) pe_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_DATA: rdata = data_q;
            ADDR_STAT: rdata = {{(DATA_W-3){1'b0}}, pe_q, fe_q, full_q};
            ADDR_CTRL: rdata = {{(DATA_W-CFG_W){1'b0}}, cfg};
            default:   rdata = '0;
        endcase
    end

    assert_err_char_no_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (ferr_i || perr_i) && !rd_data) |=> (full_q == $past(full_q)));
    assert_fe_clear_protocol_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fe_q) |-> $past(arm_fe_q && wr_stat && !wdata[1]));
    assert_pe_clear_protocol_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pe_q) |-> $past(arm_pe_q && wr_stat && !wdata[2]));
    assert_fe_set_by_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_q) |-> $past(done && ferr_i));
    assert_pe_set_by_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pe_q) |-> $past(done && perr_i));
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              line, fall, hold, done, ferr, perr;
    logic [DATA_W-1:0] char_w;
    rx_cfg_t           cfg;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .line(line), .fall(fall)
    );

    serial_rx_fsm #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line), .fall(fall),
        .cfg(cfg), .hold(hold), .done(done), .char_o(char_w),
        .ferr_o(ferr), .perr_o(perr)
    );

    serial_rx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .done(done), .char_i(char_w),
        .ferr_i(ferr), .perr_i(perr), .cfg(cfg), .hold(hold)
    );
endmodule

// File: tb/serial_rx_unit_tb_top.sv
module serial_rx_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [1:0] div_q = 2'd0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    localparam int BIT_CLKS = 64; // 16 strobes, one every 4 clocks

    always #5 clk = ~clk;

    always @(posedge clk) begin
        div_q   <= div_q + 2'd1;
        os_tick <= (div_q == 2'd3);
    end

    serial_rx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic line_bit(input logic b);
        rxd = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    function automatic logic ones_parity(input logic [7:0] d, input int n);
        logic p = 1'b0;
        for (int i = 0; i < n; i++) p ^= d[i];
        return p;
    endfunction

    task automatic send(input logic [7:0] d, input int n, input bit par_on,
                        input logic par_val, input logic stop1, input bit two, input logic stop2);
        line_bit(1'b0);
        for (int i = 0; i < n; i++) line_bit(d[i]);
        if (par_on) line_bit(par_val);
        line_bit(stop1);
        if (two) line_bit(stop2);
        line_bit(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        expect_reg(2'd0, 8'h00, "R1 data");
        expect_reg(2'd1, 8'h00, "R1 status");
        expect_reg(2'd2, 8'h00, "R1 control");

        // R3 clean 8-bit frames, LSB first
        bus_write(2'd2, 8'h01);
        send(8'hA5, 8, 0, 1'b0, 1'b1, 0, 1'b1);
        expect_reg(2'd1, 8'h01, "R3 full set");
        expect_reg(2'd0, 8'hA5, "R3 data");
        expect_reg(2'd1, 8'h00, "R3 full cleared by data read");
        send(8'h3C, 8, 0, 1'b0, 1'b1, 0, 1'b1);
        expect_reg(2'd0, 8'h3C, "R3 data second");

        // R2 short low pulse rejected
        rxd = 1'b0; repeat (16) @(negedge clk);
        rxd = 1'b1; repeat (200) @(negedge clk);
        expect_reg(2'd1, 8'h00, "R2 glitch no flag");
        expect_reg(2'd0, 8'h3C, "R2 glitch no load");
        send(8'h81, 8, 0, 1'b0, 1'b1, 0, 1'b1);
        expect_reg(2'd0, 8'h81, "R2 valid start after glitch");

        // R4 seven-bit mode
        bus_write(2'd2, 8'h03);
        send(8'hFF, 7, 0, 1'b0, 1'b1, 0, 1'b1);
        expect_reg(2'd1, 8'h01, "R4 full");
        expect_reg(2'd0, 8'h7F, "R4 bit7 zero");
        send(8'h55, 7, 0, 1'b0, 1'b1, 0, 1'b1);
        expect_reg(2'd0, 8'h55, "R4 data");

        // R5 parity even and odd, correct bits
        bus_write(2'd2, 8'h05);
        send(8'h5A, 8, 1, ones_parity(8'h5A, 8), 1'b1, 0, 1'b1);
        expect_reg(2'd1, 8'h01, "R5 even ok");
        expect_reg(2'd0, 8'h5A, "R5 even data");
        bus_write(2'd2, 8'h0D);
        send(8'h5B, 8, 1, ~ones_parity(8'h5B, 8), 1'b1, 0, 1'b1);
        expect_reg(2'd1, 8'h01, "R5 odd ok");
        expect_reg(2'd0, 8'h5B, "R5 odd data");
        // wrong parity in odd mode
        send(8'h96, 8, 1, ones_parity(8'h96, 8), 1'b1, 0, 1'b1);
        bus_write(2'd1, 8'h00); // R11 write 0 without a read that saw it
        expect_reg(2'd1, 8'h04, "R11 R5 R6 parity flag kept, full clear");
        expect_reg(2'd0, 8'h96, "R6 errored char loaded");
        // R9 blocked while flag set
        send(8'h11, 8, 1, ~ones_parity(8'h11, 8), 1'b1, 0, 1'b1);
        expect_reg(2'd0, 8'h96, "R9 data unchanged");
        expect_reg(2'd1, 8'h04, "R9 status unchanged");
        bus_write(2'd1, 8'hFF);
        expect_reg(2'd1, 8'h04, "R11 write ones no clear");
        bus_write(2'd1, 8'h00);
        expect_reg(2'd1, 8'h00, "R10 parity flag cleared");
        bus_write(2'd1, 8'h06);
        expect_reg(2'd1, 8'h00, "R11 write ones no set");

        // R7 framing error
        bus_write(2'd2, 8'h01);
        send(8'hC3, 8, 0, 1'b0, 1'b0, 0, 1'b1);
        expect_reg(2'd1, 8'h02, "R7 R6 framing flag, no full");
        expect_reg(2'd0, 8'hC3, "R6 framed char loaded");
        bus_write(2'd2, 8'h00);
        expect_reg(2'd1, 8'h02, "R12 flag retained when disabled");
        expect_reg(2'd2, 8'h00, "R12 control readback");
        bus_write(2'd1, 8'h00);
        expect_reg(2'd1, 8'h00, "R10 framing flag cleared");

        // R12 disabled: nothing received
        send(8'h42, 8, 0, 1'b0, 1'b1, 0, 1'b1);
        expect_reg(2'd1, 8'h00, "R12 no flag when disabled");
        expect_reg(2'd0, 8'hC3, "R12 no load when disabled");

        // R8 two stop bits
        bus_write(2'd2, 8'h11);
        send(8'h6E, 8, 0, 1'b0, 1'b1, 1, 1'b0);
        expect_reg(2'd1, 8'h01, "R8 second stop unchecked");
        expect_reg(2'd0, 8'h6E, "R8 data");
        send(8'h24, 8, 0, 1'b0, 1'b0, 1, 1'b1);
        expect_reg(2'd1, 8'h02, "R8 first stop checked");
        expect_reg(2'd0, 8'h24, "R8 errored data");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule